// File: doc/BRIEF.md
# Sub-Vector Swizzle Remapper

This block reorders the positions of sub-elements inside a small group of two to four sub-elements. An 8-bit swizzle word carries four 2-bit indices, one for each sub-element slot. When a request arrives, the block turns a logical sub-element index into the physical sub-element position that an operand access must use. The element address is then formed outside the block. A destination uses the group base plus the remapped position. A source uses the group base plus the position the block returns, which is the field value when swizzling is on.

Sources may read the same sub-element more than once, so their indices may repeat. A destination must be written as a true permutation of the group. When a destination swizzle repeats a position, or names a position that lies outside the current group, the block raises an illegal-instruction flag. The block holds no table and moves no data. Its inputs are the swizzle word, an active flag for the looked-up entry, the group size code, an operand kind select and the logical index. It is purely combinational, so the outputs follow the inputs within the same cycle.

Top module: `swizzle_remap`

## Requirements
- R1: When swizzling is on (active high, group size at least 2) and the logical index k is below the group size, the remapped index equals the 2-bit field at bits [2k+1:2k] of the swizzle word: k=0 uses [1:0], k=1 uses [3:2], k=2 uses [5:4] and k=3 uses [7:6].
- R2: With the active flag low, the remapped index equals the logical index and the illegal flag stays low, whatever the swizzle word holds.
- R3: The group size code maps 2'b00 to 1, 2'b01 to 2, 2'b10 to 3 and 2'b11 to 4. With code 2'b00 the remapped index equals the logical index and the illegal flag stays low.
- R4: For a source operand (isDest low), repeated field values are allowed and the illegal flag is never raised.
- R5: For a destination operand with swizzling on, two used fields holding the same value raise the illegal flag.
- R6: For a destination operand with swizzling on, a used field whose value is not below the group size raises the illegal flag.
- R7: Only the first N fields are used, where N is the group size. The values of fields N and above affect neither the remapped index nor the illegal flag.
- R8: A logical index equal to or above the group size passes through unchanged as the remapped index.
- R9: For a destination whose used fields form a permutation of 0..N-1, the illegal flag is low and each index is remapped through its field.
- R10: Both outputs are combinational functions of the present inputs and settle within the same clock period, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| swzWord | input | 8 | Four 2-bit swizzle indices; field k sits at bits [2k+1:2k] |
| swzActive | input | 1 | A swizzle entry exists for this operand |
| subvlCode | input | 2 | Group size minus one (00=1 ... 11=4) |
| isDest | input | 1 | 1 selects destination handling, 0 selects source handling |
| subIdx | input | 2 | Logical sub-element index |
| mappedIdx | output | 2 | Physical sub-element index |
| illegalInstr | output | 1 | Destination swizzle is not a valid permutation |

## Verification
Both results are due in the same cycle as the stimulus, because no register lies between the inputs and the outputs. The bench drives each input set on a falling clock edge and samples one nanosecond later, well before the next rising edge. This also covers R10. Expected values come from a reference function in the bench that is written from the requirements. A full sweep compares every swizzle word, group size, operand kind, active setting and index against that function, after directed tasks that cover each corner case one by one.

// File: rtl/swz_pkg.sv
package swz_pkg;
  // Largest group of sub-elements handled by the remapper
  localparam int SWZ_MAX_SUB = 4;
  localparam int SWZ_IDX_W   = $clog2(SWZ_MAX_SUB);
  localparam int SWZ_WORD_W  = SWZ_MAX_SUB * SWZ_IDX_W;
  localparam int SWZ_CNT_W   = SWZ_IDX_W + 1;
  localparam int SWZ_PAIRS   = SWZ_MAX_SUB * (SWZ_MAX_SUB - 1) / 2;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic                   useField;   // take remapped index from a field
    logic                   checkPerm;  // destination permutation check enabled
    logic [SWZ_MAX_SUB-1:0] usedMask;   // fields that belong to the group
    logic [SWZ_CNT_W-1:0]   groupSize;  // 1..SWZ_MAX_SUB
  } swzStrobes_t;
endpackage

// File: rtl/swz_ctrl.sv
module swz_ctrl
  import swz_pkg::*;
(
  input  logic                 swzActive,
  input  logic [SWZ_IDX_W-1:0] subvlCode,
  input  logic                 isDest,
  input  logic [SWZ_IDX_W-1:0] subIdx,
  output swzStrobes_t          strobes
);
  logic [SWZ_CNT_W-1:0]   groupSize;
  logic                   multiSub;
  logic                   idxInGroup;
  logic [SWZ_MAX_SUB-1:0] usedMask;

  assign groupSize  = {1'b0, subvlCode} + SWZ_CNT_W'(1);
  assign multiSub   = (groupSize > SWZ_CNT_W'(1));
  assign idxInGroup = ({1'b0, subIdx} < groupSize);

  for (genvar g = 0; g < SWZ_MAX_SUB; g++) begin : g_used
    localparam logic [SWZ_CNT_W-1:0] LANE = SWZ_CNT_W'(g);
    assign usedMask[g] = (LANE < groupSize);
  end

  assign strobes.useField  = swzActive & multiSub & idxInGroup;
  assign strobes.checkPerm = swzActive & multiSub & isDest;
  assign strobes.usedMask  = usedMask;
  assign strobes.groupSize = groupSize;
endmodule

// File: rtl/swz_datapath.sv
module swz_datapath
  import swz_pkg::*;
(
  input  logic [SWZ_WORD_W-1:0] swzWord,
  input  logic [SWZ_IDX_W-1:0]  subIdx,
  input  swzStrobes_t           strobes,
  output logic [SWZ_IDX_W-1:0]  mappedIdx,
  output logic                  illegalInstr
);
  logic [SWZ_IDX_W-1:0]   fieldVal [SWZ_MAX_SUB];
  logic [SWZ_MAX_SUB-1:0] outOfRange;
  logic [SWZ_PAIRS-1:0]   dupHit;

  // Split the word into per-slot indices and range-check each used one
  for (genvar g = 0; g < SWZ_MAX_SUB; g++) begin : g_field
    assign fieldVal[g]   = swzWord[g*SWZ_IDX_W +: SWZ_IDX_W];
    assign outOfRange[g] = strobes.usedMask[g] &
                           ({1'b0, fieldVal[g]} >= strobes.groupSize);
  end

  // Pairwise comparison of used slots, one comparator per unordered pair
  for (genvar a = 1; a < SWZ_MAX_SUB; a++) begin : g_pa
    for (genvar b = 0; b < a; b++) begin : g_pb
      localparam int P = a * (a - 1) / 2 + b;
      assign dupHit[P] = strobes.usedMask[a] & strobes.usedMask[b] &
                         (fieldVal[a] == fieldVal[b]);
    end
  end

  assign mappedIdx    = strobes.useField ? fieldVal[subIdx] : subIdx;
  assign illegalInstr = strobes.checkPerm & ((|outOfRange) | (|dupHit));
endmodule

// File: rtl/swizzle_remap.sv
module swizzle_remap
  import swz_pkg::*;
(
  input  logic [7:0] swzWord,
  input  logic       swzActive,
  input  logic [1:0] subvlCode,
  input  logic       isDest,
  input  logic [1:0] subIdx,
  output logic [1:0] mappedIdx,
  output logic       illegalInstr
);
  swzStrobes_t strobes;

  swz_ctrl u_ctrl (
    .swzActive (swzActive),
    .subvlCode (subvlCode),
    .isDest    (isDest),
    .subIdx    (subIdx),
    .strobes   (strobes)
  );

  swz_datapath u_dp (
    .swzWord      (swzWord),
    .subIdx       (subIdx),
    .strobes      (strobes),
    .mappedIdx    (mappedIdx),
    .illegalInstr (illegalInstr)
  );
endmodule

// File: rtl/swizzle_remap_chk.sv
module swizzle_remap_chk (
  input logic [7:0] swzWord,
  input logic       swzActive,
  input logic [1:0] subvlCode,
  input logic       isDest,
  input logic [1:0] subIdx,
  input logic [1:0] mappedIdx,
  input logic       illegalInstr
);
  always_comb begin
    AST_FIELD_SELECT: assert (!(swzActive && subvlCode != 2'd0 && subIdx <= subvlCode)
                              || mappedIdx == swzWord[subIdx*2 +: 2])
      else $error("field select mismatch"); // R1
    AST_INACTIVE_IDENTITY: assert (swzActive || (mappedIdx == subIdx && !illegalInstr))
      else $error("inactive entry altered mapping"); // R2
    AST_SINGLE_IDENTITY: assert (subvlCode != 2'd0 || (mappedIdx == subIdx && !illegalInstr))
      else $error("group of one altered mapping"); // R3
    AST_SRC_LEGAL: assert (isDest || !illegalInstr)
      else $error("source flagged illegal"); // R4
    AST_DEST_DUP: assert (!(swzActive && isDest && subvlCode == 2'd3 &&
                            swzWord[1:0] == swzWord[3:2]) || illegalInstr)
      else $error("destination duplicate not flagged"); // R5
    AST_DEST_RANGE: assert (!(swzActive && isDest && subvlCode == 2'd1 &&
                              swzWord[1:0] > 2'd1) || illegalInstr)
      else $error("destination out-of-group index not flagged"); // R6
    AST_BEYOND_PASS: assert (subIdx <= subvlCode || mappedIdx == subIdx)
      else $error("index beyond group altered"); // R8
  end
endmodule

bind swizzle_remap swizzle_remap_chk u_chk (
  .swzWord      (swzWord),
  .swzActive    (swzActive),
  .subvlCode    (subvlCode),
  .isDest       (isDest),
  .subIdx       (subIdx),
  .mappedIdx    (mappedIdx),
  .illegalInstr (illegalInstr)
);

// File: tb/swizzle_remap_test.sv
`timescale 1ns/1ps
module swizzle_remap_test;
  logic       clk = 1'b0;
  logic [7:0] swzWord = '0;
  logic       swzActive = 1'b0;
  logic [1:0] subvlCode = '0;
  logic       isDest = 1'b0;
  logic [1:0] subIdx = '0;
  logic [1:0] mappedIdx;
  logic       illegalInstr;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  swizzle_remap uut (
    .swzWord(swzWord), .swzActive(swzActive), .subvlCode(subvlCode),
    .isDest(isDest), .subIdx(subIdx), .mappedIdx(mappedIdx),
    .illegalInstr(illegalInstr)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 150000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Inputs change on the falling edge; outputs are sampled 1 ns later (R10)
  task automatic drive(input logic [7:0] w, input logic act, input logic [1:0] code,
                       input logic dst, input logic [1:0] k);
    @(negedge clk);
    swzWord = w; swzActive = act; subvlCode = code; isDest = dst; subIdx = k;
    #1;
  endtask

  task automatic expect_out(input string req, input logic [1:0] expM, input logic expI);
    total++;
    if (mappedIdx !== expM || illegalInstr !== expI) begin
      bad++;
      $display("FAIL %s: mapped=%0d illegal=%0d expected mapped=%0d illegal=%0d (w=%h act=%0d code=%0d dst=%0d k=%0d)",
               req, mappedIdx, illegalInstr, expM, expI, swzWord, swzActive, subvlCode, isDest, subIdx);
    end
  endtask

  // Reference from the requirements
  function automatic logic [2:0] ref_model(input logic [7:0] w, input logic act,
                                           input logic [1:0] code, input logic dst,
                                           input logic [1:0] k);
    int n = int'(code) + 1;
    logic [1:0] m = k;
    logic ill = 1'b0;
    if (act && n > 1) begin
      if (int'(k) < n) m = w[2*k +: 2];
      if (dst) begin
        for (int i = 0; i < n; i++) begin
          if (int'(w[2*i +: 2]) >= n) ill = 1'b1;
          for (int j = 0; j < i; j++)
            if (w[2*i +: 2] == w[2*j +: 2]) ill = 1'b1;
        end
      end
    end
    return {ill, m};
  endfunction

  task automatic t_idle();  // R2: quiet inputs give identity
    for (int k = 0; k < 4; k++) begin
      drive(8'h00, 1'b0, 2'd0, 1'b0, 2'(k));
      expect_out("R2 idle", 2'(k), 1'b0);
    end
  endtask

  task automatic t_inactive();  // R2
    for (int k = 0; k < 4; k++) begin
      drive(8'h00, 1'b0, 2'd3, 1'b1, 2'(k));
      expect_out("R2 inactive dest", 2'(k), 1'b0);
      drive(8'h1B, 1'b0, 2'd3, 1'b0, 2'(k));
      expect_out("R2 inactive src", 2'(k), 1'b0);
    end
  endtask

  task automatic t_field_pos();  // R1: 8'h4E -> 2,3,0,1 ; 8'h1B -> 3,2,1,0
    logic [1:0] e4e [4] = '{2'd2, 2'd3, 2'd0, 2'd1};
    for (int k = 0; k < 4; k++) begin
      drive(8'h4E, 1'b1, 2'd3, 1'b0, 2'(k));
      expect_out("R1 field 4E", e4e[k], 1'b0);
      drive(8'h1B, 1'b1, 2'd3, 1'b0, 2'(k));
      expect_out("R1 field 1B", 2'(3 - k), 1'b0);
    end
  endtask

  task automatic t_single();  // R3
    for (int k = 0; k < 4; k++) begin
      drive(8'h00, 1'b1, 2'd0, 1'b1, 2'(k));
      expect_out("R3 group of one", 2'(k), 1'b0);
    end
  endtask

  task automatic t_src_dup();  // R4
    for (int k = 0; k < 4; k++) begin
      drive(8'hFF, 1'b1, 2'd3, 1'b0, 2'(k));
      expect_out("R4 src duplicates", 2'd3, 1'b0);
    end
    drive(8'h05, 1'b1, 2'd3, 1'b0, 2'd1);
    expect_out("R4 src duplicates 05", 2'd1, 1'b0);
  endtask

  task automatic t_dest_dup();  // R5: fields 1,1,0,0
    drive(8'h05, 1'b1, 2'd3, 1'b1, 2'd0);
    expect_out("R5 dest duplicate", 2'd1, 1'b1);
    drive(8'h00, 1'b1, 2'd1, 1'b1, 2'd0);
    expect_out("R5 dest duplicate size2", 2'd0, 1'b1);
  endtask

  task automatic t_dest_range();  // R6
    drive(8'h08, 1'b1, 2'd1, 1'b1, 2'd1);   // fields 0,2 in group of 2
    expect_out("R6 dest range size2", 2'd2, 1'b1);
    drive(8'h13, 1'b1, 2'd2, 1'b1, 2'd0);   // fields 3,0,1 in group of 3
    expect_out("R6 dest range size3", 2'd3, 1'b1);
  endtask

  task automatic t_unused();  // R7
    drive(8'h51, 1'b1, 2'd1, 1'b1, 2'd0);   // used 1,0 ; unused 1,1
    expect_out("R7 unused size2 k0", 2'd1, 1'b0);
    drive(8'h51, 1'b1, 2'd1, 1'b1, 2'd1);
    expect_out("R7 unused size2 k1", 2'd0, 1'b0);
    drive(8'h92, 1'b1, 2'd2, 1'b1, 2'd0);   // used 2,0,1 ; unused 2
    expect_out("R7 unused size3 k0", 2'd2, 1'b0);
    drive(8'h92, 1'b1, 2'd2, 1'b1, 2'd2);
    expect_out("R7 unused size3 k2", 2'd1, 1'b0);
  endtask

  task automatic t_beyond();  // R8
    drive(8'h1B, 1'b1, 2'd1, 1'b0, 2'd2);
    expect_out("R8 beyond group k2", 2'd2, 1'b0);
    drive(8'h1B, 1'b1, 2'd1, 1'b0, 2'd3);
    expect_out("R8 beyond group k3", 2'd3, 1'b0);
    drive(8'h1B, 1'b1, 2'd2, 1'b0, 2'd3);
    expect_out("R8 beyond group size3", 2'd3, 1'b0);
  endtask

  task automatic t_perm();  // R9
    logic [1:0] e4e [4] = '{2'd2, 2'd3, 2'd0, 2'd1};
    for (int k = 0; k < 4; k++) begin
      drive(8'h4E, 1'b1, 2'd3, 1'b1, 2'(k));
      expect_out("R9 dest permutation", e4e[k], 1'b0);
    end
  endtask

  task automatic t_sweep();  // R1..R10 against the reference
    logic [2:0] r;
    for (int w = 0; w < 256; w++)
      for (int c = 0; c < 4; c++)
        for (int d = 0; d < 2; d++)
          for (int a = 0; a < 2; a++)
            for (int k = 0; k < 4; k++) begin
              drive(8'(w), 1'(a), 2'(c), 1'(d), 2'(k));
              r = ref_model(8'(w), 1'(a), 2'(c), 1'(d), 2'(k));
              expect_out("R10 sweep", r[1:0], r[2]);
            end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_idle();
    t_inactive();
    t_field_pos();
    t_single();
    t_src_dup();
    t_dest_dup();
    t_dest_range();
    t_unused();
    t_beyond();
    t_perm();
    t_sweep();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule